// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the 8-bit power control register of an 8051-class microcontroller and sequences the two low-power modes the register selects. The register sits on the special function register bus. It answers a write at a fixed address. It is not bit-addressable, so a write always replaces the whole byte. Two mode bits choose between the modes. Idle gates only the CPU clock and leaves the oscillator running. Power-down also requests that the oscillator stop.

Each mode takes its own way out. In idle, any enabled interrupt clears the idle bit in hardware. A reset also ends idle, but only once the reset pin has been held for a full qualification window. In power-down the oscillator is assumed stopped, so interrupts have no effect and the reset pin acts on the next clock edge. While a mode is active, the block drives the external pin policy. It forces the address latch strobe and the program store strobe, floats the low address/data port when code runs from external memory, and selects what the high address port shows. The baud-doubling bit and the two general-purpose flags are held here for other blocks to use.

Top module: `lpm_ctrl`

## Requirements
- R1: After a qualified reset the register reads 00h, `cpu_clk_en` and `osc_run` are 1, and every pin override output is 0.
- R2: A write with `sfr_addr` = 87h loads the byte into the register. Bit 7 is baud-double, bits 3:2 are the general flags, bit 1 is power-down and bit 0 is idle. Bits 6:4 store the value but have no effect. A write to any other address leaves the register unchanged.
- R3: Setting bit 0 enters idle. `cpu_clk_en` falls one clock after the write edge and `osc_run` stays 1.
- R4: Setting bit 1 enters power-down. One clock after the write edge, `osc_run` and `cpu_clk_en` are both 0.
- R5: A write that sets bits 1 and 0 together enters power-down, and bit 0 reads back as 0.
- R6: In idle, `irq_pend` clears bit 0 at the next edge and leaves the other bits as they were. `cpu_clk_en` returns to 1 one clock after that.
- R7: In power-down, `irq_pend` has no effect on the register or the outputs.
- R8: Outside power-down, a reset takes effect only after `rst_pin` has been high at RST_HOLD (24) consecutive clock edges. A shorter pulse changes nothing.
- R9: In power-down, `rst_pin` high at a clock edge resets the block at that edge.
- R10: In idle, `ale_ovr`/`psen_ovr` are 1 and `ale_lvl`/`psen_lvl` are 1. In power-down, the overrides are 1 and the levels are 0. In run mode, all four are 0.
- R11: `p0_float` is 1 in either mode while `ext_prog` is 1. `p2_addr_sel` is 1 only in idle with `ext_prog` = 1. `p2_latch_sel` is 1 in power-down.
- R12: Register writes are ignored while idle or power-down is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_pin | input | 1 | Raw reset pin, active high |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | AW (8) | SFR write address |
| sfr_wdata | input | 8 | SFR write data |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_prog | input | 1 | Code is fetched from external program memory |
| pcon_rd | output | 8 | Current register contents |
| baud_dbl | output | 1 | Baud-rate doubling bit |
| cpu_clk_en | output | 1 | Registered CPU clock enable |
| osc_run | output | 1 | Oscillator run request |
| ale_ovr | output | 1 | Address latch strobe override active |
| ale_lvl | output | 1 | Forced address latch strobe level |
| psen_ovr | output | 1 | Program store strobe override active |
| psen_lvl | output | 1 | Forced program store strobe level |
| p0_float | output | 1 | Float the low address/data port |
| p2_addr_sel | output | 1 | High port shows the address |
| p2_latch_sel | output | 1 | High port shows its latch data |

## Verification
A wrong mode bit shows in `pcon_rd` on the cycle after the offending edge. It shows in the clock, oscillator and pin outputs one cycle later again, because these are registered from the mode bits. A wrong reset qualification count shows as a reset that lands one edge early or late, or that never lands. For this reason the stimulus holds the pin for a short pulse and for a full window, both in idle and in power-down. The reference model runs every cycle, so a fault is reported on the first clock where a port differs.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int REG_W   = 8;
    localparam int B_BAUD  = 7;
    localparam int B_GF_HI = 3;
    localparam int B_GF_LO = 2;
    localparam int B_PD    = 1;
    localparam int B_IDL   = 0;

    typedef struct packed {
        logic       baud;
        logic [2:0] spare;
        logic [1:0] gflag;
        logic       pd;
        logic       idl;
    } pcon_t;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } pmode_e;

    typedef struct packed {
        logic cpu_clk_en;
        logic osc_run;
        logic ale_ovr;
        logic ale_lvl;
        logic psen_ovr;
        logic psen_lvl;
        logic p0_float;
        logic p2_addr;
        logic p2_latch;
    } pinst_t;

    localparam pinst_t PINS_RUN = '{
        cpu_clk_en: 1'b1, osc_run: 1'b1, ale_ovr: 1'b0, ale_lvl: 1'b0,
        psen_ovr: 1'b0, psen_lvl: 1'b0, p0_float: 1'b0, p2_addr: 1'b0,
        p2_latch: 1'b0 };

    function automatic logic [REG_W-1:0] pcon_pack(input pcon_t r);
        logic [REG_W-1:0] v;
        v = '0;
        v[B_BAUD]          = r.baud;
        v[6:4]             = r.spare;
        v[B_GF_HI:B_GF_LO] = r.gflag;
        v[B_PD]            = r.pd;
        v[B_IDL]           = r.idl;
        return v;
    endfunction

endpackage

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
    parameter int RST_HOLD = 24
) (
    input  logic clk,
    input  logic rst_pin,
    input  logic pd_active,
    output logic chip_rst
);
    localparam int CW = $clog2(RST_HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(RST_HOLD);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          full;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != HOLD_V)
            cnt_d = cnt_q + 1'b1;
    end

    // A low pin clears the count at once; only an unbroken high run counts.
    always_ff @(posedge clk or negedge rst_pin) begin
        if (!rst_pin) cnt_q <= '0;
        else          cnt_q <= cnt_d;
    end

    assign full = (cnt_q == HOLD_V);
    // In power-down the oscillator is stopped, so the pin acts directly.
    assign chip_rst = full | (rst_pin & pd_active);

    p_qual_needs_pin_r8: assert property (@(posedge clk) disable iff (!rst_pin)
        $rose(full) |-> $past(rst_pin))
        else $error("R8 qualified reset without a held pin");

endmodule

// File: rtl/lpm_reg.sv
module lpm_reg
    import lpm_pkg::*;
#(
    parameter int              AW       = 8,
    parameter logic [AW-1:0]   SFR_ADDR = AW'(8'h87)
) (
    input  logic             clk,
    input  logic             chip_rst,
    input  logic             sfr_wr,
    input  logic [AW-1:0]    sfr_addr,
    input  logic [REG_W-1:0] sfr_wdata,
    input  logic             irq_pend,
    output pcon_t            pcon_q
);
    pcon_t pcon_d;
    logic  hit, busy;

    always_comb begin
        pcon_d = pcon_q;
        hit    = sfr_wr && (sfr_addr == SFR_ADDR);
        busy   = pcon_q.pd || pcon_q.idl;
        if (pcon_q.idl && !pcon_q.pd) begin
            if (irq_pend) pcon_d.idl = 1'b0;
        end else if (hit && !busy) begin
            pcon_d.baud  = sfr_wdata[B_BAUD];
            pcon_d.spare = sfr_wdata[6:4];
            pcon_d.gflag = sfr_wdata[B_GF_HI:B_GF_LO];
            pcon_d.pd    = sfr_wdata[B_PD];
            // Power-down wins when both mode bits arrive together.
            pcon_d.idl   = sfr_wdata[B_IDL] && !sfr_wdata[B_PD];
        end
    end

    always_ff @(posedge clk) begin
        if (chip_rst) pcon_q <= '0;
        else          pcon_q <= pcon_d;
    end

    p_mode_excl_r5: assert property (@(posedge clk) disable iff (chip_rst)
        !(pcon_q.pd && pcon_q.idl))
        else $error("R5 both mode bits set");

    p_pd_sticky_r7: assert property (@(posedge clk) disable iff (chip_rst)
        pcon_q.pd |=> pcon_q.pd)
        else $error("R7 power-down left without reset");

    p_idle_wake_r6: assert property (@(posedge clk) disable iff (chip_rst)
        (pcon_q.idl && irq_pend) |=> !pcon_q.idl)
        else $error("R6 idle not cleared by interrupt");

    p_no_write_busy_r12: assert property (@(posedge clk) disable iff (chip_rst)
        (pcon_q.pd || (pcon_q.idl && !irq_pend)) |=> $stable(pcon_q))
        else $error("R12 register changed during a low-power mode");

endmodule

// File: rtl/lpm_pin_ctl.sv
module lpm_pin_ctl
    import lpm_pkg::*;
(
    input  logic   clk,
    input  logic   chip_rst,
    input  logic   pd,
    input  logic   idl,
    input  logic   ext_prog,
    output pinst_t pins_q
);
    pinst_t pins_d;
    pmode_e mode;

    always_comb begin
        if (pd)       mode = MODE_PDOWN;
        else if (idl) mode = MODE_IDLE;
        else          mode = MODE_RUN;

        pins_d = PINS_RUN;
        case (mode)
            MODE_IDLE: begin
                pins_d.cpu_clk_en = 1'b0;
                pins_d.ale_ovr    = 1'b1;
                pins_d.ale_lvl    = 1'b1;
                pins_d.psen_ovr   = 1'b1;
                pins_d.psen_lvl   = 1'b1;
                pins_d.p0_float   = ext_prog;
                pins_d.p2_addr    = ext_prog;
            end
            MODE_PDOWN: begin
                pins_d.cpu_clk_en = 1'b0;
                pins_d.osc_run    = 1'b0;
                pins_d.ale_ovr    = 1'b1;
                pins_d.psen_ovr   = 1'b1;
                pins_d.p0_float   = ext_prog;
                pins_d.p2_latch   = 1'b1;
            end
            default: pins_d = PINS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (chip_rst) pins_q <= PINS_RUN;
        else          pins_q <= pins_d;
    end

    p_pd_pins_r10: assert property (@(posedge clk) disable iff (chip_rst)
        pd |=> (pins_q.ale_ovr && !pins_q.ale_lvl && pins_q.psen_ovr && !pins_q.psen_lvl))
        else $error("R10 power-down strobe levels");

    p_idle_pins_r11: assert property (@(posedge clk) disable iff (chip_rst)
        (idl && !pd) |=> (pins_q.p2_addr == $past(ext_prog)) && !pins_q.p2_latch)
        else $error("R11 idle port select");

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int            AW       = 8,
    parameter logic [AW-1:0] SFR_ADDR = AW'(8'h87),
    parameter int            RST_HOLD = 24
) (
    input  logic          clk,
    input  logic          rst_pin,
    input  logic          sfr_wr,
    input  logic [AW-1:0] sfr_addr,
    input  logic [7:0]    sfr_wdata,
    input  logic          irq_pend,
    input  logic          ext_prog,
    output logic [7:0]    pcon_rd,
    output logic          baud_dbl,
    output logic          cpu_clk_en,
    output logic          osc_run,
    output logic          ale_ovr,
    output logic          ale_lvl,
    output logic          psen_ovr,
    output logic          psen_lvl,
    output logic          p0_float,
    output logic          p2_addr_sel,
    output logic          p2_latch_sel
);
    logic   chip_rst;
    pcon_t  pcon_q;
    pinst_t pins_q;

    lpm_rst_qual #(.RST_HOLD(RST_HOLD)) u_rst (
        .clk       (clk),
        .rst_pin   (rst_pin),
        .pd_active (pcon_q.pd),
        .chip_rst  (chip_rst)
    );

    lpm_reg #(.AW(AW), .SFR_ADDR(SFR_ADDR)) u_reg (
        .clk       (clk),
        .chip_rst  (chip_rst),
        .sfr_wr    (sfr_wr),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .irq_pend  (irq_pend),
        .pcon_q    (pcon_q)
    );

    lpm_pin_ctl u_pins (
        .clk      (clk),
        .chip_rst (chip_rst),
        .pd       (pcon_q.pd),
        .idl      (pcon_q.idl),
        .ext_prog (ext_prog),
        .pins_q   (pins_q)
    );

    assign pcon_rd      = pcon_pack(pcon_q);
    assign baud_dbl     = pcon_q.baud;
    assign cpu_clk_en   = pins_q.cpu_clk_en;
    assign osc_run      = pins_q.osc_run;
    assign ale_ovr      = pins_q.ale_ovr;
    assign ale_lvl      = pins_q.ale_lvl;
    assign psen_ovr     = pins_q.psen_ovr;
    assign psen_lvl     = pins_q.psen_lvl;
    assign p0_float     = pins_q.p0_float;
    assign p2_addr_sel  = pins_q.p2_addr;
    assign p2_latch_sel = pins_q.p2_latch;

    p_idle_clk_r3: assert property (@(posedge clk) disable iff (chip_rst)
        (pcon_q.idl && !pcon_q.pd) |=> (!cpu_clk_en && osc_run))
        else $error("R3 idle clock gating");

    p_pd_osc_r4: assert property (@(posedge clk) disable iff (chip_rst)
        pcon_q.pd |=> (!osc_run && !cpu_clk_en))
        else $error("R4 power-down oscillator");

    p_pd_reset_r9: assert property (@(posedge clk)
        (pcon_q.pd && rst_pin) |=> (pcon_rd == 8'h00 && osc_run))
        else $error("R9 power-down reset");

endmodule

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;
    localparam int  RST_HOLD = 24;
    localparam time TCK      = 20ns;

    logic       clk = 1'b0;
    logic       rst_pin = 1'b0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic       irq_pend = 1'b0;
    logic       ext_prog = 1'b0;
    logic [7:0] pcon_rd;
    logic       baud_dbl, cpu_clk_en, osc_run, ale_ovr, ale_lvl;
    logic       psen_ovr, psen_lvl, p0_float, p2_addr_sel, p2_latch_sel;

    int vectors = 0;
    int miscmp  = 0;
    bit done    = 0;

    always #(TCK/2) clk = ~clk;

    lpm_ctrl #(.RST_HOLD(RST_HOLD)) i_lpm_ctrl (
        .clk(clk), .rst_pin(rst_pin), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .irq_pend(irq_pend), .ext_prog(ext_prog),
        .pcon_rd(pcon_rd), .baud_dbl(baud_dbl), .cpu_clk_en(cpu_clk_en),
        .osc_run(osc_run), .ale_ovr(ale_ovr), .ale_lvl(ale_lvl),
        .psen_ovr(psen_ovr), .psen_lvl(psen_lvl), .p0_float(p0_float),
        .p2_addr_sel(p2_addr_sel), .p2_latch_sel(p2_latch_sel)
    );

    // Reference model: behaviour from the requirements, updated per edge.
    bit         m_valid = 0;
    int         hi_run  = 0;
    logic [7:0] m_reg   = 8'h00;
    logic       e_cpu = 1, e_osc = 1, e_aovr = 0, e_alvl = 0, e_povr = 0;
    logic       e_plvl = 0, e_p0 = 0, e_p2a = 0, e_p2l = 0;

    always @(posedge clk) begin
        bit do_rst, idle, pdn, hit;
        idle   = m_reg[0];
        pdn    = m_reg[1];
        do_rst = rst_pin && ((hi_run >= RST_HOLD) || (m_valid && pdn)); // R8 R9
        hi_run = rst_pin ? hi_run + 1 : 0;
        if (do_rst) begin
            m_valid = 1;
            m_reg   = 8'h00;
            {e_cpu, e_osc, e_aovr, e_alvl, e_povr, e_plvl, e_p0, e_p2a, e_p2l} = 9'b110000000;
        end else if (m_valid) begin
            e_cpu  = !(idle || pdn);
            e_osc  = !pdn;
            e_aovr = idle || pdn;
            e_povr = idle || pdn;
            e_alvl = idle && !pdn;
            e_plvl = idle && !pdn;
            e_p0   = (idle || pdn) && ext_prog;
            e_p2a  = idle && !pdn && ext_prog;
            e_p2l  = pdn;
            hit = sfr_wr && sfr_addr == 8'h87;
            if (pdn) begin
                // R7 R12: nothing changes
            end else if (idle) begin
                if (irq_pend) m_reg[0] = 1'b0;
            end else if (hit) begin
                m_reg = sfr_wdata;
                if (sfr_wdata[1]) m_reg[0] = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input string nm, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk("R1,R2,R5,R6", "pcon_rd", pcon_rd, m_reg);
            chk("R2", "baud_dbl", {7'd0, baud_dbl}, {7'd0, m_reg[7]});
            chk("R3,R4", "cpu_clk_en", {7'd0, cpu_clk_en}, {7'd0, e_cpu});
            chk("R4,R9", "osc_run", {7'd0, osc_run}, {7'd0, e_osc});
            chk("R10", "ale", {6'd0, ale_ovr, ale_lvl}, {6'd0, e_aovr, e_alvl});
            chk("R10", "psen", {6'd0, psen_ovr, psen_lvl}, {6'd0, e_povr, e_plvl});
            chk("R11", "ports", {5'd0, p0_float, p2_addr_sel, p2_latch_sel}, {5'd0, e_p0, e_p2a, e_p2l});
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        tick(1);
        sfr_wr = 1'b0;
    endtask

    task automatic hold_rst(input int n);
        rst_pin = 1'b1;
        tick(n);
        rst_pin = 1'b0;
    endtask

    initial begin
        #1 rst_pin = 1'b1;
        tick(RST_HOLD + 4);              // R1 R8: full window from power-up
        rst_pin = 1'b0;
        tick(3);
        wr(8'h87, 8'h8C);                // R2 baud and flags
        tick(2);
        wr(8'h86, 8'hFF);                // R2 other address ignored
        tick(2);
        wr(8'h87, 8'h7C);                // R2 spare bits stored
        tick(2);
        irq_pend = 1'b1; tick(2); irq_pend = 1'b0; // R6 interrupt in run has no effect
        ext_prog = 1'b1;
        wr(8'h87, 8'h05);                // R3 R10 R11 idle, external code
        tick(4);
        wr(8'h87, 8'h02);                // R12 ignored in idle
        tick(2);
        irq_pend = 1'b1; tick(1); irq_pend = 1'b0; // R6 wake
        tick(4);
        ext_prog = 1'b0;
        wr(8'h87, 8'h09);                // R3 idle, internal code
        tick(3);
        hold_rst(RST_HOLD - 4);          // R8 short pulse, still idle
        tick(3);
        hold_rst(RST_HOLD + 2);          // R8 full window ends idle
        tick(3);
        wr(8'h87, 8'h8F);                // R5 both mode bits -> power-down
        tick(4);
        irq_pend = 1'b1; tick(3); irq_pend = 1'b0; // R7 ignored
        wr(8'h87, 8'h00);                // R12 ignored in power-down
        tick(3);
        hold_rst(1);                     // R9 one edge ends power-down
        tick(3);
        ext_prog = 1'b1;
        wr(8'h87, 8'hFE);                // R4 R11 power-down, external code
        tick(5);
        hold_rst(2);                     // R9
        tick(4);
        wr(8'h87, 8'h03);                // R5 again
        tick(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        #(TCK * 5000);
        if (!done) begin
            done = 1;
            miscmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end
endmodule